// File: doc/BRIEF.md
# Four-Digit Decimal Step Counter

This block holds a four-digit decimal value between 0000 and 9999 and moves it by one at a programmable rate. A direction switch picks up or down counting. A 7-bit speed field sets the step period as a multiple of a fixed base interval. Three push buttons act on the count: one holds it where it is while pressed, one presets it to 0000, and one presets it to 9999. The four digits come out as packed BCD nibbles, ready for a display driver.

Every switch and button passes through a two-flop synchroniser. A small controller has four states. `ST_RUN` lets prescaler ticks step the count. `ST_HOLD` ignores them. `ST_LOAD_LO` and `ST_LOAD_HI` each last one cycle and load 0000 or 9999.

The next state does not depend on the current state. It is chosen by priority: a rising edge of the zero button leads to `ST_LOAD_LO`. Otherwise a rising edge of the max button leads to `ST_LOAD_HI`. Otherwise a held pause button leads to `ST_HOLD`. In every other case the controller goes to `ST_RUN`. Each digit is its own register with local carry or borrow, and the carry ripples from the units digit upward.

Top module: `bcd_step_counter`

## Requirements
- R1: While reset is asserted and after it is released, `digits_o` reads 0000.
- R2: With `dir_sw` = 0 and no button pressed, each step adds one to the value. The step carries between digits in decimal. `digits_o[3:0]` is the units digit, `[7:4]` the tens, `[11:8]` the hundreds and `[15:12]` the thousands. No nibble ever exceeds 9.
- R3: With `dir_sw` = 1, each step subtracts one and borrows between digits in decimal.
- R4: Counting up from 9999 gives 0000.
- R5: Counting down from 0000 gives 9999.
- R6: Steps in free running come every (`speed_sw` + 1) × `BASE_CYCLES` clock cycles. `speed_sw` = 0 is the fastest rate.
- R7: A change of the synchronised speed field restarts the prescaler. The first step after the change follows (new speed + 1) × `BASE_CYCLES` cycles after the restart.
- R8: A rising edge of `btn_zero` loads 0000 four clock edges after the input rises. While the button stays held, no further load takes place and counting goes on.
- R9: A rising edge of `btn_max` loads 9999 with the same latency as R8.
- R10: When both preset buttons rise together, the value becomes 0000.
- R11: While `btn_pause` is held, the value does not change. A preset edge during the pause still loads its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_sw | input | 1 | Count sense: 0 up, 1 down |
| speed_sw | input | SPEED_W | Step-rate field, 0 fastest |
| btn_zero | input | 1 | Preset to 0000 on press |
| btn_max | input | 1 | Preset to 9999 on press |
| btn_pause | input | 1 | Hold count while pressed |
| digits_o | output | DIGITS*4 | Packed BCD digits, units in the low nibble |

## Verification
The bound checker watches these properties on every cycle:
- every nibble stays in 0..9;
- each load state produces its preset on the next edge;
- `ST_HOLD`, and `ST_RUN` without a tick, leave the value unchanged;
- a tick at 9999 going up gives 0000, and a tick at 0000 going down gives 9999.

Some behaviour only the bench scenarios can show:
- the step period for each speed;
- the prescaler restart when the speed field changes;
- the synchroniser and edge latency;
- the priority between the two presets;
- that a held preset button loads only once.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_LOAD_LO = 2'd2,
        ST_LOAD_HI = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/bcd_sync2.sv
module bcd_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/bcd_rate_gen.sv
module bcd_rate_gen #(
    parameter int BASE_CYCLES = 1_000_000,
    parameter int SPEED_W     = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed,
    output logic               step_tick
);
    localparam int BASE_W = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;

    logic [BASE_W-1:0]  base_q;
    logic [SPEED_W-1:0] mult_q;
    logic [SPEED_W-1:0] last_speed_q;
    logic               base_tick;
    logic               restart;

    assign restart   = (speed != last_speed_q);
    assign base_tick = (base_q == BASE_W'(BASE_CYCLES - 1));
    assign step_tick = base_tick && (mult_q == speed) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q       <= '0;
            mult_q       <= '0;
            last_speed_q <= '0;
        end else begin
            last_speed_q <= speed;
            if (restart) begin
                base_q <= '0;
                mult_q <= '0;
            end else begin
                base_q <= base_tick ? '0 : base_q + BASE_W'(1);
                if (base_tick)
                    mult_q <= (mult_q == speed) ? '0 : mult_q + SPEED_W'(1);
            end
        end
    end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
    import bcd_cnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_lo,
    input  logic               load_hi,
    input  logic               step,
    input  logic               count_down,
    output logic [DIGIT_W-1:0] digit_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            digit_q <= '0;
        else if (load_lo)
            digit_q <= '0;
        else if (load_hi)
            digit_q <= DIGIT_W'(9);
        else if (step) begin
            if (count_down)
                digit_q <= (digit_q == '0) ? DIGIT_W'(9) : digit_q - DIGIT_W'(1);
            else
                digit_q <= (digit_q == DIGIT_W'(9)) ? '0 : digit_q + DIGIT_W'(1);
        end
    end
endmodule

// File: rtl/bcd_step_counter.sv
module bcd_step_counter
    import bcd_cnt_pkg::*;
#(
    parameter int DIGITS      = 4,
    parameter int SPEED_W     = 7,
    parameter int BASE_CYCLES = 1_000_000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dir_sw,
    input  logic [SPEED_W-1:0]        speed_sw,
    input  logic                      btn_zero,
    input  logic                      btn_max,
    input  logic                      btn_pause,
    output logic [DIGITS*DIGIT_W-1:0] digits_o
);
    localparam int SYNC_W = SPEED_W + 4;

    logic [SYNC_W-1:0]  sync_q;
    logic               dir_s, pause_s, zero_s, max_s;
    logic [SPEED_W-1:0] speed_s;
    logic               zero_prev_q, max_prev_q;
    logic               zero_rise, max_rise;
    logic               step_tick;
    ctl_state_t         state_q, state_d;
    logic               load_lo, load_hi, run_step;
    logic [DIGITS-1:0]  step_en;

    bcd_sync2 #(.WIDTH(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dir_sw, btn_pause, btn_zero, btn_max, speed_sw}),
        .q     (sync_q)
    );

    assign {dir_s, pause_s, zero_s, max_s, speed_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_prev_q <= 1'b0;
            max_prev_q  <= 1'b0;
        end else begin
            zero_prev_q <= zero_s;
            max_prev_q  <= max_s;
        end
    end

    assign zero_rise = zero_s & ~zero_prev_q;
    assign max_rise  = max_s & ~max_prev_q;

    bcd_rate_gen #(.BASE_CYCLES(BASE_CYCLES), .SPEED_W(SPEED_W)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed     (speed_s),
        .step_tick (step_tick)
    );

    // Next state: the choice is independent of the present state, by priority.
    always_comb begin
        if (zero_rise)
            state_d = ST_LOAD_LO;
        else if (max_rise)
            state_d = ST_LOAD_HI;
        else if (pause_s)
            state_d = ST_HOLD;
        else
            state_d = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        load_lo  = 1'b0;
        load_hi  = 1'b0;
        run_step = 1'b0;
        unique case (state_q)
            ST_RUN:     run_step = step_tick;
            ST_HOLD:    run_step = 1'b0;
            ST_LOAD_LO: load_lo  = 1'b1;
            ST_LOAD_HI: load_hi  = 1'b1;
            default:    run_step = 1'b0;
        endcase
    end

    assign step_en[0] = run_step;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [DIGIT_W-1:0] val;

        bcd_digit u_digit (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_lo    (load_lo),
            .load_hi    (load_hi),
            .step       (step_en[g]),
            .count_down (dir_s),
            .digit_q    (val)
        );

        assign digits_o[g*DIGIT_W +: DIGIT_W] = val;

        if (g < DIGITS - 1) begin : g_carry
            assign step_en[g+1] = step_en[g] &
                (dir_s ? (val == '0) : (val == DIGIT_W'(9)));
        end
    end
endmodule

// File: rtl/bcd_step_counter_chk.sv
module bcd_step_counter_chk
    import bcd_cnt_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [DIGITS*DIGIT_W-1:0] digits_o,
    input ctl_state_t                state_q,
    input logic                      run_step,
    input logic                      dir_s
);
    localparam logic [DIGITS*DIGIT_W-1:0] ALL_NINE = {DIGITS{4'h9}};

    for (genvar g = 0; g < DIGITS; g++) begin : g_rng
        // R2
        digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            digits_o[g*DIGIT_W +: DIGIT_W] <= DIGIT_W'(9));
    end

    // R8
    load_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOAD_LO |=> digits_o == '0);

    // R9
    load_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOAD_HI |=> digits_o == ALL_NINE);

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HOLD |=> $stable(digits_o));

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !run_step) |=> $stable(digits_o));

    // R4
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_step && !dir_s && digits_o == ALL_NINE) |=> digits_o == '0);

    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_step && dir_s && digits_o == '0) |=> digits_o == ALL_NINE);
endmodule

bind bcd_step_counter bcd_step_counter_chk #(.DIGITS(DIGITS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .digits_o (digits_o),
    .state_q  (state_q),
    .run_step (run_step),
    .dir_s    (dir_s)
);

// File: tb/test_bcd_step_counter.sv
module test_bcd_step_counter;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 5;
    localparam int SPW        = 7;
    localparam int NVEC       = 7;
    localparam int WAIT_LIMIT = 20000;

    typedef struct packed {
        logic [1:0]  preset;   // 0 none, 1 zero, 2 max
        logic        dir;
        logic [6:0]  speed;
        logic [15:0] nsteps;
        logic [15:0] exp_val;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 1'b0, 7'd0, 16'd12,   16'h0012, 4'd2},
        '{2'd2, 1'b1, 7'd1, 16'd3,    16'h9996, 4'd3},
        '{2'd2, 1'b0, 7'd0, 16'd3,    16'h0002, 4'd4},
        '{2'd1, 1'b1, 7'd2, 16'd3,    16'h9997, 4'd5},
        '{2'd0, 1'b0, 7'd0, 16'd5,    16'h0002, 4'd4},
        '{2'd1, 1'b0, 7'd0, 16'd105,  16'h0105, 4'd2},
        '{2'd2, 1'b1, 7'd0, 16'd1000, 16'h8999, 4'd3}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dir_sw = 1'b0;
    logic [SPW-1:0] speed_sw = '0;
    logic           btn_zero = 1'b0;
    logic           btn_max = 1'b0;
    logic           btn_pause = 1'b0;
    logic [15:0]    digits_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_step_counter #(.DIGITS(4), .SPEED_W(SPW), .BASE_CYCLES(BASE)) i_bcd_step_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_sw    (dir_sw),
        .speed_sw  (speed_sw),
        .btn_zero  (btn_zero),
        .btn_max   (btn_max),
        .btn_pause (btn_pause),
        .digits_o  (digits_o)
    );

    function automatic string req_name(input int r);
        case (r)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_zero();
        btn_zero = 1'b1; cycles(4); btn_zero = 1'b0; cycles(4);
    endtask

    task automatic press_max();
        btn_max = 1'b1; cycles(4); btn_max = 1'b0; cycles(4);
    endtask

    // Wait for one change of the value; returns negedges waited (-1 on timeout)
    task automatic wait_change(output int gap);
        logic [15:0] prev;
        prev = digits_o;
        gap = -1;
        for (int c = 1; c <= WAIT_LIMIT; c++) begin
            @(negedge clk);
            if (digits_o !== prev) begin
                gap = c;
                break;
            end
        end
    endtask

    task automatic run_vec(input vec_t v);
        int gap;
        int n;
        logic [15:0] held;
        btn_pause = 1'b1;
        cycles(4);
        if (v.preset == 2'd1) begin
            press_zero();
            chk("R8 R11 preset zero while paused", digits_o, 16'h0000);
        end else if (v.preset == 2'd2) begin
            press_max();
            chk("R9 R11 preset max while paused", digits_o, 16'h9999);
        end
        dir_sw   = v.dir;
        speed_sw = v.speed;
        cycles(4);
        btn_pause = 1'b0;
        n = 0;
        while (n < int'(v.nsteps)) begin
            wait_change(gap);
            if (gap < 0) begin
                fails++;
                $display("FAIL %s: no step seen, got timeout expected step", req_name(v.req));
                break;
            end
            n++;
            if (n == int'(v.nsteps)) btn_pause = 1'b1;
            if (n == 3)
                chk_rng("R6 step period", gap, (int'(v.speed) + 1) * BASE, (int'(v.speed) + 1) * BASE);
        end
        chk(req_name(v.req), digits_o, v.exp_val);
        held = digits_o;
        cycles(40);
        chk("R11 value held while paused", digits_o, held);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int gap;
        cycles(3);
        chk("R1 value during reset", digits_o, 16'h0000);
        rst_n = 1'b1;
        btn_pause = 1'b1;
        cycles(2);
        chk("R1 value after reset", digits_o, 16'h0000);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R10: both preset buttons rise together
        btn_zero = 1'b1; btn_max = 1'b1;
        cycles(4);
        btn_zero = 1'b0; btn_max = 1'b0;
        cycles(4);
        chk("R10 both presets give zero", digits_o, 16'h0000);

        // R8: held zero button loads once, counting continues
        press_max();
        btn_zero = 1'b1;
        cycles(4);
        chk("R8 zero load while held", digits_o, 16'h0000);
        dir_sw = 1'b0; speed_sw = 7'd0;
        cycles(4);
        btn_pause = 1'b0;
        cycles(40);
        checks++;
        if (digits_o == 16'h0000) begin
            fails++;
            $display("FAIL R8: got %h expected nonzero after held button", digits_o);
        end
        btn_pause = 1'b1;
        btn_zero = 1'b0;
        cycles(6);

        // R7: speed change restarts the prescaler
        speed_sw = 7'd20;
        cycles(4);
        btn_pause = 1'b0;
        wait_change(gap);
        cycles(60);
        speed_sw = 7'd21;
        wait_change(gap);
        chk_rng("R7 restart on speed change", gap + 60, 172, 174);
        btn_pause = 1'b1;
        cycles(6);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule